// File: doc/BRIEF.md
# Display-Link Bus-Switch Command Sequencer

This block sits between a display controller and a byte-level I2C master. Before the controller reads EDID or PROM contents behind a display-link encoder, the encoder's I2C pass-through has to be pointed at the right downstream bus. On a `start` pulse the sequencer runs a fixed three-phase command protocol against the encoder, which is reached at a configurable device address (commonly 0x70 or 0x72):

- It writes a one-hot bus-select argument and closes that transfer with a STOP.
- It writes the switch opcode.
- It polls the encoder's status register, retrying a bounded number of times while the encoder answers "pending".

A closing STOP and a wait for an idle bus end the sequence. The result is reported on a `done` pulse together with `ok`.

The I2C master is driven through a single-cycle request interface. Each request carries an operation, a device address, a register index, a write byte and a stop flag. The master answers each request with a one-cycle completion that carries an error flag and a read byte. The master must accept a request in the cycle it is raised. The master reports whether the bus is idle on a separate level input.

Top module: `bsw_seq`

## Requirements
- R1: The first request after an accepted start is a write (txn_op = 2'b00) to index 0x07 with txn_stop = 1, and its data is the one-hot bus select: bus_sel 0 (PROM) gives 0x01, 1 (DDC1) gives 0x02, 2 (DDC2) gives 0x04, and 3 gives 0x00.
- R2: After the argument write completes, and after the closing STOP completes, the sequencer raises no request and no done until bus_idle is seen high.
- R3: The second request is a write of 0x7A to index 0x08 with txn_stop = 0.
- R4: Status is read with read requests (txn_op = 2'b01) to index 0x09 with txn_stop = 0. A further read follows only if the previous one returned 0x04 or completed with txn_err, and there are at most MAX_TRIES (default 3) reads.
- R5: After the status phase, one stop-only request (txn_op = 2'b10, txn_stop = 1) is issued, and done follows once the bus is idle.
- R6: ok is 1 with done exactly when the last status read completed without error and returned 0x01; any other final result, including a pending value on the last attempt, gives ok = 0.
- R7: A txn_err on the argument or opcode write ends the sequence: done rises with ok = 0 in the cycle after that completion, and no further request is issued.
- R8: Every request of a sequence carries on txn_addr the tgt_addr value captured when start was accepted.
- R9: start is ignored while busy is high: the sequence in progress keeps its captured address and bus select, and exactly one done pulse results.
- R10: done and txn_req are each high for exactly one cycle at a time, and busy is low out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| tgt_addr | input | ADDR_W | Encoder device address for the sequence |
| bus_sel | input | 2 | Downstream bus code (0 PROM, 1 DDC1, 2 DDC2) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| ok | output | 1 | Result, valid while done is high |
| txn_req | output | 1 | One-cycle request to the I2C master |
| txn_op | output | 2 | 00 write, 01 read, 10 stop only |
| txn_addr | output | ADDR_W | Device address of the request |
| txn_index | output | 8 | Register index of the request |
| txn_wdata | output | 8 | Write byte |
| txn_stop | output | 1 | Issue STOP after the transfer |
| txn_done | input | 1 | One-cycle completion from the master |
| txn_err | input | 1 | Completion failed (valid with txn_done) |
| txn_rdata | input | 8 | Read byte (valid with txn_done) |
| bus_idle | input | 1 | Master reports the bus free |

## Verification
The bench targets the retry edges of the status poll:

- A success on the third read shows whether the design stops polling one attempt too early.
- Three pending answers show whether it stops at the bound and reports failure, rather than looping or reporting the stale pending value as success.
- A failed status read must be treated as a spent attempt and not as a final answer.
- A non-pending failure code on the first read must end the poll at once.

Errors in the argument and opcode phases are timed to the cycle, which catches a design that still issues a STOP or keeps going. The bench holds bus_idle low after every STOP and flags any request raised in that window. A second start injected mid-sequence with a different address and bus select exposes a design that re-captures its inputs.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

  localparam logic [7:0] IDX_ARG    = 8'h07;
  localparam logic [7:0] IDX_OPC    = 8'h08;
  localparam logic [7:0] IDX_STAT   = 8'h09;
  localparam logic [7:0] OPC_SWITCH = 8'h7A;
  localparam logic [7:0] ST_PEND    = 8'h04;
  localparam logic [7:0] ST_PASS    = 8'h01;

  typedef enum logic [1:0] {
    OP_WR   = 2'b00,
    OP_RD   = 2'b01,
    OP_STOP = 2'b10
  } txn_op_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ARG_REQ,
    S_ARG_WAIT,
    S_ARG_IDLE,
    S_OPC_REQ,
    S_OPC_WAIT,
    S_POL_REQ,
    S_POL_WAIT,
    S_STP_REQ,
    S_STP_WAIT,
    S_STP_IDLE,
    S_FINISH
  } seq_state_t;

  // bus code -> one-hot argument byte
  function automatic logic [7:0] sel_to_onehot(input logic [1:0] code);
    logic [7:0] v;
    v = 8'h00;
    if (code != 2'd3) v[code] = 1'b1;
    return v;
  endfunction

  // another poll is wanted after this completion
  function automatic logic status_again(input logic err, input logic [7:0] st);
    return err || (st == ST_PEND);
  endfunction

  // completion counts as success
  function automatic logic status_pass(input logic err, input logic [7:0] st);
    return !err && (st == ST_PASS);
  endfunction

endpackage

// File: rtl/bsw_try_ctr.sv
module bsw_try_ctr #(
  parameter int MAX_TRIES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CNT_W = $clog2(MAX_TRIES + 1);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) count <= '0;
    else if (inc)      count <= count + 1'b1;
  end

  // the attempt now in flight is the final one allowed
  assign last = (count == CNT_W'(MAX_TRIES - 1));

  AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(MAX_TRIES)) else $error("try count past bound"); // R4

  AST_NO_INC_PAST_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && last && !clr) |=> (count == CNT_W'(MAX_TRIES))) else $error("count step"); // R4

endmodule

// File: rtl/bsw_req_build.sv
module bsw_req_build
  import bsw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  seq_state_t        state,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [1:0]        cap_sel,
  output logic              req,
  output logic [1:0]        op,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        index,
  output logic [7:0]        wdata,
  output logic              stop
);
  always_comb begin
    req   = 1'b0;
    op    = OP_WR;
    index = 8'h00;
    wdata = 8'h00;
    stop  = 1'b0;
    unique case (state)
      S_ARG_REQ: begin
        req = 1'b1; op = OP_WR; index = IDX_ARG;
        wdata = sel_to_onehot(cap_sel); stop = 1'b1;
      end
      S_OPC_REQ: begin
        req = 1'b1; op = OP_WR; index = IDX_OPC; wdata = OPC_SWITCH;
      end
      S_POL_REQ: begin
        req = 1'b1; op = OP_RD; index = IDX_STAT;
      end
      S_STP_REQ: begin
        req = 1'b1; op = OP_STOP; stop = 1'b1;
      end
      default: ;
    endcase
  end

  assign addr = cap_addr;

endmodule

// File: rtl/bsw_seq.sv
module bsw_seq
  import bsw_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MAX_TRIES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [1:0]        bus_sel,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic              txn_req,
  output logic [1:0]        txn_op,
  output logic [ADDR_W-1:0] txn_addr,
  output logic [7:0]        txn_index,
  output logic [7:0]        txn_wdata,
  output logic              txn_stop,
  input  logic              txn_done,
  input  logic              txn_err,
  input  logic [7:0]        txn_rdata,
  input  logic              bus_idle
);
  seq_state_t        state, state_nx;
  logic [ADDR_W-1:0] cap_addr;
  logic [1:0]        cap_sel;
  logic              ok_q;
  logic              last_try;

  // named events for the assertions
  logic start_acc, abort_evt, poll_done, poll_again;

  assign start_acc  = (state == S_IDLE) && start;
  assign poll_done  = (state == S_POL_WAIT) && txn_done;
  assign poll_again = poll_done && status_again(txn_err, txn_rdata) && !last_try;
  assign abort_evt  = txn_done && txn_err &&
                      ((state == S_ARG_WAIT) || (state == S_OPC_WAIT));

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:     if (start) state_nx = S_ARG_REQ;
      S_ARG_REQ:  state_nx = S_ARG_WAIT;
      S_ARG_WAIT: if (txn_done) state_nx = txn_err ? S_FINISH : S_ARG_IDLE;
      S_ARG_IDLE: if (bus_idle) state_nx = S_OPC_REQ;
      S_OPC_REQ:  state_nx = S_OPC_WAIT;
      S_OPC_WAIT: if (txn_done) state_nx = txn_err ? S_FINISH : S_POL_REQ;
      S_POL_REQ:  state_nx = S_POL_WAIT;
      S_POL_WAIT: if (txn_done) state_nx = poll_again ? S_POL_REQ : S_STP_REQ;
      S_STP_REQ:  state_nx = S_STP_WAIT;
      S_STP_WAIT: if (txn_done) state_nx = S_STP_IDLE;
      S_STP_IDLE: if (bus_idle) state_nx = S_FINISH;
      S_FINISH:   state_nx = S_IDLE;
      default:    state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cap_addr <= '0;
      cap_sel  <= '0;
      ok_q     <= 1'b0;
    end else begin
      state <= state_nx;
      if (start_acc) begin
        cap_addr <= tgt_addr;
        cap_sel  <= bus_sel;
        ok_q     <= 1'b0;
      end else if (poll_done) begin
        ok_q <= status_pass(txn_err, txn_rdata);
      end
    end
  end

  bsw_try_ctr #(.MAX_TRIES(MAX_TRIES)) u_try (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_acc),
    .inc   (poll_done),
    .last  (last_try)
  );

  bsw_req_build #(.ADDR_W(ADDR_W)) u_req (
    .state    (state),
    .cap_addr (cap_addr),
    .cap_sel  (cap_sel),
    .req      (txn_req),
    .op       (txn_op),
    .addr     (txn_addr),
    .index    (txn_index),
    .wdata    (txn_wdata),
    .stop     (txn_stop)
  );

  assign busy = (state != S_IDLE);
  assign done = (state == S_FINISH);
  assign ok   = ok_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done wider than one cycle"); // R10

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    txn_req |=> !txn_req) else $error("request wider than one cycle"); // R10

  AST_OPC_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && txn_index == IDX_OPC) |-> $past(bus_idle)) else $error("opcode before idle"); // R2

  AST_POLL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && txn_op == OP_RD) |-> (txn_index == IDX_STAT && !txn_stop)) else $error("poll form"); // R4

  AST_ABORT_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (done && !ok)) else $error("abort not immediate"); // R7

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(cap_addr) && $stable(cap_sel)) else $error("start taken while busy"); // R9

  AST_RETRY_ONLY_ON_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    poll_again |-> (txn_err || txn_rdata == ST_PEND)) else $error("retry without cause"); // R4

endmodule

// File: tb/bsw_seq_tb.sv
module bsw_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] tgt_addr = 8'h00;
  logic [1:0] bus_sel = 2'd0;
  logic       busy, done, ok, txn_req, txn_stop;
  logic [1:0] txn_op;
  logic [7:0] txn_addr, txn_index, txn_wdata;
  logic       txn_done = 1'b0, txn_err = 1'b0, bus_idle = 1'b1;
  logic [7:0] txn_rdata = 8'h00;

  always #4 clk = ~clk;

  bsw_seq #(.ADDR_W(8), .MAX_TRIES(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_addr(tgt_addr), .bus_sel(bus_sel),
    .busy(busy), .done(done), .ok(ok), .txn_req(txn_req), .txn_op(txn_op),
    .txn_addr(txn_addr), .txn_index(txn_index), .txn_wdata(txn_wdata), .txn_stop(txn_stop),
    .txn_done(txn_done), .txn_err(txn_err), .txn_rdata(txn_rdata), .bus_idle(bus_idle)
  );

  int checks = 0, errors = 0;
  int cyc = 0, done_cnt = 0, done_cyc = 0, err_cyc = 0, idle_viol = 0;
  int lg_n = 0, pend = 0, cur = 0, idle_cnt = 0;
  logic [1:0] lg_op   [0:15];
  logic [7:0] lg_idx  [0:15];
  logic [7:0] lg_dat  [0:15];
  logic [7:0] lg_adr  [0:15];
  logic       lg_stop [0:15];
  logic       rs_err  [0:15];
  logic [7:0] rs_data [0:15];
  logic       last_ok = 1'b0;

  // master model and monitor
  always @(negedge clk) begin
    cyc++;
    if (done) begin done_cnt++; done_cyc = cyc; last_ok = ok; end
    if (txn_req) begin
      if (!bus_idle) idle_viol++;
      if (lg_n < 16) begin
        lg_op[lg_n] = txn_op; lg_idx[lg_n] = txn_index; lg_dat[lg_n] = txn_wdata;
        lg_adr[lg_n] = txn_addr; lg_stop[lg_n] = txn_stop;
        cur = lg_n;
      end
      lg_n++;
      pend = 2;
    end
    txn_done = 1'b0;
    txn_err  = 1'b0;
    if (idle_cnt > 0) begin
      idle_cnt--;
      if (idle_cnt == 0) bus_idle = 1'b1;
    end
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        txn_done  = 1'b1;
        txn_err   = rs_err[cur];
        txn_rdata = rs_data[cur];
        if (rs_err[cur]) err_cyc = cyc;
        if (lg_stop[cur]) begin bus_idle = 1'b0; idle_cnt = 3; end
      end
    end
  end

  task automatic chk(input logic cond, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] onehot_of(input logic [1:0] c);
    case (c)
      2'd0: return 8'h01;
      2'd1: return 8'h02;
      2'd2: return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

  // one scenario: scripted master answers, expected trace built from the requirements
  task automatic run_case(input logic [7:0] addr, input logic [1:0] sel,
                          input logic arg_err, input logic opc_err,
                          input logic [2:0] rd_err, input logic [7:0] d0,
                          input logic [7:0] d1, input logic [7:0] d2,
                          input logic poke);
    logic [1:0] e_op [0:15];
    logic [7:0] e_idx [0:15];
    logic [7:0] e_dat [0:15];
    logic       e_stop [0:15];
    logic [7:0] rd [0:2];
    int e_n;
    logic e_ok;
    logic aborted;
    rd[0] = d0; rd[1] = d1; rd[2] = d2;
    for (int i = 0; i < 16; i++) begin rs_err[i] = 1'b0; rs_data[i] = 8'h00; end
    rs_err[0] = arg_err; rs_err[1] = opc_err;
    for (int t = 0; t < 3; t++) begin rs_err[2+t] = rd_err[t]; rs_data[2+t] = rd[t]; end

    e_n = 0; e_ok = 1'b0; aborted = 1'b0;
    e_op[0] = 2'b00; e_idx[0] = 8'h07; e_dat[0] = onehot_of(sel); e_stop[0] = 1'b1; e_n = 1;
    if (arg_err) aborted = 1'b1;
    else begin
      e_op[1] = 2'b00; e_idx[1] = 8'h08; e_dat[1] = 8'h7A; e_stop[1] = 1'b0; e_n = 2;
      if (opc_err) aborted = 1'b1;
      else begin
        for (int t = 0; t < 3; t++) begin
          e_op[e_n] = 2'b01; e_idx[e_n] = 8'h09; e_dat[e_n] = 8'h00; e_stop[e_n] = 1'b0; e_n++;
          e_ok = !rd_err[t] && rd[t] == 8'h01;
          if (!rd_err[t] && rd[t] != 8'h04) break;
        end
        e_op[e_n] = 2'b10; e_idx[e_n] = 8'h00; e_dat[e_n] = 8'h00; e_stop[e_n] = 1'b1; e_n++;
      end
    end

    lg_n = 0; done_cnt = 0; idle_viol = 0; err_cyc = 0;
    @(negedge clk);
    tgt_addr = addr; bus_sel = sel; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      chk(busy == 1'b1, "R9", "busy during sequence", busy, 1);
      tgt_addr = 8'h10; bus_sel = ~sel; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (6) @(negedge clk);

    chk(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
    chk(lg_n == e_n, "R4", "request count", lg_n, e_n);
    for (int i = 0; i < e_n && i < lg_n; i++) begin
      chk(lg_op[i] == e_op[i], "R5", $sformatf("op of request %0d", i), lg_op[i], e_op[i]);
      chk(lg_idx[i] == e_idx[i], "R3", $sformatf("index of request %0d", i), lg_idx[i], e_idx[i]);
      if (e_op[i] == 2'b00)
        chk(lg_dat[i] == e_dat[i], "R1", $sformatf("data of request %0d", i), lg_dat[i], e_dat[i]);
      chk(lg_stop[i] == e_stop[i], "R5", $sformatf("stop of request %0d", i), lg_stop[i], e_stop[i]);
      chk(lg_adr[i] == addr, "R8", $sformatf("address of request %0d", i), lg_adr[i], addr);
    end
    chk(last_ok == e_ok, "R6", "ok at done", last_ok, e_ok);
    chk(idle_viol == 0, "R2", "requests while bus busy", idle_viol, 0);
    if (aborted)
      chk(done_cyc == err_cyc + 1, "R7", "done cycle after error", done_cyc - err_cyc, 1);
    chk(busy == 1'b0, "R9", "busy after done", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin rs_err[i] = 1'b0; rs_data[i] = 8'h00; lg_stop[i] = 1'b0; end
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && txn_req == 1'b0, "R10", "reset outputs",
        {busy, done, txn_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R6: immediate success, DDC1
    run_case(8'h70, 2'd1, 1'b0, 1'b0, 3'b000, 8'h01, 8'h00, 8'h00, 1'b0);
    // R4: two pending then success, PROM
    run_case(8'h72, 2'd0, 1'b0, 1'b0, 3'b000, 8'h04, 8'h04, 8'h01, 1'b0);
    // R4 R6: pending on every attempt -> fail at bound
    run_case(8'h70, 2'd2, 1'b0, 1'b0, 3'b000, 8'h04, 8'h04, 8'h04, 1'b0);
    // R4: failed read spends an attempt, then success
    run_case(8'h72, 2'd1, 1'b0, 1'b0, 3'b001, 8'h00, 8'h01, 8'h00, 1'b0);
    // R6: non-pending failure code ends polling
    run_case(8'h70, 2'd3, 1'b0, 1'b0, 3'b000, 8'h02, 8'h01, 8'h01, 1'b0);
    // R4 R6: every read fails
    run_case(8'h70, 2'd1, 1'b0, 1'b0, 3'b111, 8'h01, 8'h01, 8'h01, 1'b0);
    // R7: argument write fails
    run_case(8'h72, 2'd1, 1'b1, 1'b0, 3'b000, 8'h01, 8'h00, 8'h00, 1'b0);
    // R7: opcode write fails
    run_case(8'h70, 2'd2, 1'b0, 1'b1, 3'b000, 8'h01, 8'h00, 8'h00, 1'b0);
    // R9: second start mid-sequence is ignored
    run_case(8'h72, 2'd2, 1'b0, 1'b0, 3'b000, 8'h04, 8'h01, 8'h00, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule